// File: doc/BRIEF.md
# Status Pin Source Selector

This block decides what a serially controlled frequency synthesizer shows on its single open-drain status pin. A three-bit selection code chooses the source. The choices are: released, a pull-down while the phase-locked loop is out of lock, a flag that marks the end of a frequency-counter measurement, the level of a general input port, or the level of a bidirectional I/O pin. The pin is modelled as an active-low drive enable. When `pinDriveLow` is 1 the pin is pulled low. When it is 0 the driver is off, and an external pull-up makes the line high.

Serial-bus activity takes priority over the selection code. While chip-enable is high during a write transfer, the pin is released. During a read transfer the pin carries the internal serial output bit. The end-of-count source is a small sequence held in a flag register:

- A done strobe sets the flag.
- A 0-to-1 transition of the count-enable level clears it.
- A rising edge of chip-enable also clears it.
- When a clear and a set fall in the same cycle, the clear wins.

The pin output is registered. Every combinational source therefore appears one clock after it is sampled.

Top module: `stat_pin_sel`

## Requirements
- R1: While `rstN` is low, `pinDriveLow` is 0 (pin released).
- R2: When `chipEn`=1 and `readXfer`=0 at a clock edge, `pinDriveLow` is 0 after that edge, whatever `modeCode` and the other inputs are.
- R3: When `chipEn`=1 and `readXfer`=1 at a clock edge, `pinDriveLow` equals the inverse of `serOut` after that edge, whatever `modeCode` is.
- R4: With `chipEn`=0, the codes 3'b000, 3'b011, 3'b100 and 3'b111 give `pinDriveLow`=0 one edge later.
- R5: With `chipEn`=0 and code 3'b001, `pinDriveLow` equals the inverse of `pllLocked` one edge later.
- R6: With code 3'b010, a one-cycle `cntDone` sampled at edge k sets the end-of-count flag. `pinDriveLow` is 1 after edge k+1.
- R7: A 0-to-1 transition of `cntStart` sampled at edge k clears the end-of-count flag. With code 3'b010, `pinDriveLow` is 0 after edge k+1. A 1-to-0 transition of `cntStart` has no effect.
- R8: A rising edge of `chipEn` clears the end-of-count flag. After the transfer ends, code 3'b010 keeps the pin released.
- R9: When a clear (rising `cntStart` or rising `chipEn`) and `cntDone` are sampled at the same edge, the flag ends up clear.
- R10: With `chipEn`=0 and code 3'b101, `pinDriveLow` is the inverse of `portInLvl` when `portIsAlt`=0, and is 0 when `portIsAlt`=1, one edge later.
- R11: With `chipEn`=0 and code 3'b110, `pinDriveLow` is the inverse of `ioLvl` when `ioIsOut`=0, and is 0 when `ioIsOut`=1, one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeCode | input | 3 | Status pin source selection code |
| chipEn | input | 1 | Serial chip-enable, high during a transfer |
| readXfer | input | 1 | 1 = the current transfer is a read, 0 = a write |
| serOut | input | 1 | Internal serial output bit |
| cntStart | input | 1 | Count-enable level; a rising edge starts a measurement |
| cntDone | input | 1 | One-cycle strobe that marks the end of a measurement |
| pllLocked | input | 1 | 1 = loop in lock |
| portInLvl | input | 1 | Level of the general input port |
| portIsAlt | input | 1 | 1 = the shared port pin is in its other function |
| ioLvl | input | 1 | Level of the bidirectional I/O pin |
| ioIsOut | input | 1 | 1 = the I/O pin is set as an output |
| pinDriveLow | output | 1 | 1 = pull the status pin low, 0 = release it |

## Verification
A wrong source decode shows up within a single clock as a wrong pin level. This holds in each code and in each bus phase. The bench sweeps every code with its inputs held at values that would pull the pin low if the decode were wrong. An end-of-count flag that is set or cleared wrongly shows two edges after the strobe in code 3'b010. It also stays visible across later cycles, so the bench checks the pin after set, after clear, after a falling count-enable and after a chip-enable pulse. The bench also checks the same-cycle clear-versus-set case.

// File: rtl/statpin_pkg.sv
package statpin_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] CODE_UNLOCK = 3'b001;
  localparam logic [MODE_W-1:0] CODE_EOC    = 3'b010;
  localparam logic [MODE_W-1:0] CODE_PORT   = 3'b101;
  localparam logic [MODE_W-1:0] CODE_IO     = 3'b110;

  typedef enum logic [2:0] {
    SRC_OPEN,
    SRC_UNLOCK,
    SRC_EOC,
    SRC_PORT,
    SRC_IO,
    SRC_SER
  } pinSrc_e;

  typedef struct packed {
    logic    eocSet;
    logic    eocClr;
    pinSrc_e src;
  } pinStrobe_t;
endpackage

// File: rtl/statpin_ctrl.sv
module statpin_ctrl
  import statpin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeCode,
  input  logic              chipEn,
  input  logic              readXfer,
  input  logic              cntStart,
  input  logic              cntDone,
  input  logic              portIsAlt,
  input  logic              ioIsOut,
  output pinStrobe_t        strobes
);
  logic chipEnQ;
  logic cntStartQ;
  logic chipEnRise;
  logic cntStartRise;

  // Previous-cycle copies for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chipEnQ   <= 1'b0;
      cntStartQ <= 1'b0;
    end else begin
      chipEnQ   <= chipEn;
      cntStartQ <= cntStart;
    end
  end

  assign chipEnRise   = chipEn & ~chipEnQ;
  assign cntStartRise = cntStart & ~cntStartQ;

  pinSrc_e srcSel;

  always_comb begin
    srcSel = SRC_OPEN;
    if (chipEn) begin
      srcSel = readXfer ? SRC_SER : SRC_OPEN;
    end else begin
      unique case (modeCode)
        CODE_UNLOCK: srcSel = SRC_UNLOCK;
        CODE_EOC:    srcSel = SRC_EOC;
        CODE_PORT:   srcSel = portIsAlt ? SRC_OPEN : SRC_PORT;
        CODE_IO:     srcSel = ioIsOut ? SRC_OPEN : SRC_IO;
        default:     srcSel = SRC_OPEN;
      endcase
    end
  end

  assign strobes.eocSet = cntDone;
  assign strobes.eocClr = chipEnRise | cntStartRise;
  assign strobes.src    = srcSel;

  // R8: a rising chip-enable must request a flag clear
  p_ce_rise_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(chipEn) && $past(rstN)) |-> strobes.eocClr);

  // R2: a write transfer never selects a driving source
  p_write_selects_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && !readXfer) |-> (strobes.src == SRC_OPEN));
endmodule

// File: rtl/statpin_dp.sv
module statpin_dp
  import statpin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pinStrobe_t strobes,
  input  logic       serOut,
  input  logic       pllLocked,
  input  logic       portInLvl,
  input  logic       ioLvl,
  output logic       pinDriveLow
);
  logic eocFlag;
  logic driveNext;

  // End-of-count flag: a clear beats a set in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                eocFlag <= 1'b0;
    else if (strobes.eocClr)  eocFlag <= 1'b0;
    else if (strobes.eocSet)  eocFlag <= 1'b1;
  end

  always_comb begin
    unique case (strobes.src)
      SRC_SER:    driveNext = ~serOut;
      SRC_UNLOCK: driveNext = ~pllLocked;
      SRC_EOC:    driveNext = eocFlag;
      SRC_PORT:   driveNext = ~portInLvl;
      SRC_IO:     driveNext = ~ioLvl;
      default:    driveNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinDriveLow <= 1'b0;
    else       pinDriveLow <= driveNext;
  end

  // R9: a clear request always leaves the flag clear
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.eocClr |=> !eocFlag);

  // R6: a set with no clear leaves the flag set
  p_done_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.eocSet && !strobes.eocClr) |=> eocFlag);
endmodule

// File: rtl/stat_pin_sel.sv
module stat_pin_sel
  import statpin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeCode,
  input  logic              chipEn,
  input  logic              readXfer,
  input  logic              serOut,
  input  logic              cntStart,
  input  logic              cntDone,
  input  logic              pllLocked,
  input  logic              portInLvl,
  input  logic              portIsAlt,
  input  logic              ioLvl,
  input  logic              ioIsOut,
  output logic              pinDriveLow
);
  pinStrobe_t strobes;

  statpin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .chipEn(chipEn),
    .readXfer(readXfer), .cntStart(cntStart), .cntDone(cntDone),
    .portIsAlt(portIsAlt), .ioIsOut(ioIsOut), .strobes(strobes)
  );

  statpin_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .serOut(serOut),
    .pllLocked(pllLocked), .portInLvl(portInLvl), .ioLvl(ioLvl),
    .pinDriveLow(pinDriveLow)
  );

  // R1: released while in reset
  always_comb begin
    if (!rstN) p_reset_open_r1: assert (pinDriveLow == 1'b0);
  end

  // R3: a read transfer mirrors the inverted serial bit
  p_read_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && readXfer) |=> (pinDriveLow == !$past(serOut)));

  // R2: a write transfer releases the pin
  p_write_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && !readXfer) |=> !pinDriveLow);

  // R5: the unlock code mirrors the inverted lock status
  p_unlock_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEn && modeCode == CODE_UNLOCK) |=> (pinDriveLow == !$past(pllLocked)));

  // R4: the open codes never drive
  p_open_codes_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEn && (modeCode == 3'b000 || modeCode == 3'b011 ||
                 modeCode == 3'b100 || modeCode == 3'b111)) |=> !pinDriveLow);

  // R10: port in its other function releases the pin
  p_port_alt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEn && modeCode == CODE_PORT && portIsAlt) |=> !pinDriveLow);

  // R11: I/O pin set as output releases the pin
  p_io_out_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEn && modeCode == CODE_IO && ioIsOut) |=> !pinDriveLow);
endmodule

// File: tb/sim_stat_pin_sel.sv
module sim_stat_pin_sel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modeCode = 3'b000;
  logic chipEn = 0, readXfer = 0, serOut = 0, cntStart = 0, cntDone = 0;
  logic pllLocked = 0, portInLvl = 0, portIsAlt = 0, ioLvl = 0, ioIsOut = 0;
  logic pinDriveLow;

  always #10 clk = ~clk;

  stat_pin_sel u0 (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .chipEn(chipEn),
    .readXfer(readXfer), .serOut(serOut), .cntStart(cntStart),
    .cntDone(cntDone), .pllLocked(pllLocked), .portInLvl(portInLvl),
    .portIsAlt(portIsAlt), .ioLvl(ioLvl), .ioIsOut(ioIsOut),
    .pinDriveLow(pinDriveLow)
  );

  typedef struct {
    int    due;
    logic  val;
    string tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expectAt(input int lat, input logic v, input string tag);
    item_t it;
    it.due = cyc + lat;
    it.val = v;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compare due items away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (pinDriveLow !== it.val) begin
        failures++;
        $display("FAIL %s cyc=%0d pinDriveLow=%b expected=%b", it.tag, cyc, pinDriveLow, it.val);
      end
    end
  end

  initial begin
    step(2);
    checks++;
    if (pinDriveLow !== 1'b0) begin
      failures++;
      $display("FAIL R1 pinDriveLow=%b expected=0", pinDriveLow);
    end
    rstN = 1'b1;
    step(2);

    // R4: open codes with every source set to pull low
    pllLocked = 0; portInLvl = 0; ioLvl = 0;
    foreach (sbq[i]) ;
    modeCode = 3'b000; expectAt(1, 0, "R4"); step();
    modeCode = 3'b011; expectAt(1, 0, "R4"); step();
    modeCode = 3'b100; expectAt(1, 0, "R4"); step();
    modeCode = 3'b111; expectAt(1, 0, "R4"); step();

    // R5: unlock indication
    modeCode = 3'b001; pllLocked = 0; expectAt(1, 1, "R5"); step();
    pllLocked = 1; expectAt(1, 0, "R5"); step();
    pllLocked = 0; expectAt(1, 1, "R5"); step();

    // R2: write transfer overrides a driving mode
    chipEn = 1; readXfer = 0; expectAt(1, 0, "R2"); step();
    // R3: read transfer follows the inverted serial bit
    readXfer = 1; serOut = 0; expectAt(1, 1, "R3"); step();
    serOut = 1; expectAt(1, 0, "R3"); step();
    modeCode = 3'b000; serOut = 0; expectAt(1, 1, "R3"); step();
    chipEn = 0; readXfer = 0; expectAt(1, 0, "R4"); step();

    // R10: input-port source
    modeCode = 3'b101; portIsAlt = 0; portInLvl = 0; expectAt(1, 1, "R10"); step();
    portInLvl = 1; expectAt(1, 0, "R10"); step();
    portInLvl = 0; portIsAlt = 1; expectAt(1, 0, "R10"); step();
    portIsAlt = 0;

    // R11: I/O-pin source
    modeCode = 3'b110; ioIsOut = 0; ioLvl = 0; expectAt(1, 1, "R11"); step();
    ioLvl = 1; expectAt(1, 0, "R11"); step();
    ioLvl = 0; ioIsOut = 1; expectAt(1, 0, "R11"); step();
    ioIsOut = 0;

    // R7/R6: start a count, then end it
    modeCode = 3'b010; cntStart = 1; expectAt(2, 0, "R7"); step(); step();
    cntDone = 1; expectAt(2, 1, "R6"); step();
    cntDone = 0; step();
    cntStart = 0; expectAt(2, 1, "R7"); step(2);
    cntStart = 1; expectAt(2, 0, "R7"); step(2);
    cntDone = 1; expectAt(2, 1, "R6"); step();
    cntDone = 0; step();

    // R8: a chip-enable pulse clears the flag
    chipEn = 1; readXfer = 0; expectAt(1, 0, "R2"); step();
    chipEn = 0; expectAt(1, 0, "R8"); expectAt(3, 0, "R8"); step(3);

    // R9: count start rising and done in the same cycle
    cntStart = 0; step();
    cntDone = 1; expectAt(2, 1, "R6"); step();
    cntDone = 0; step();
    cntStart = 1; cntDone = 1; expectAt(2, 0, "R9"); expectAt(4, 0, "R9"); step();
    cntDone = 0; step(4);

    // R9: chip-enable rising and done in the same cycle
    cntDone = 1; expectAt(2, 1, "R6"); step();
    cntDone = 0; step();
    chipEn = 1; cntDone = 1; step();
    chipEn = 0; cntDone = 0; expectAt(1, 0, "R9"); expectAt(3, 0, "R9"); step(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule